// File: doc/BRIEF.md
# Camera Pixel Output Formatter

The formatter sits between an image pipeline and a parallel camera video link. It takes a stream of 12-bit pixels qualified by a valid strobe and by line-valid and frame-valid flags. It reduces each pixel to the selected depth of 12, 10 or 8 bits, and it places the result on the link's output port buses. In single-channel mode each accepted pixel leaves on port A, one per output strobe. In dual-output mode pixels are paired within a line: the even pixel goes to port A and the odd pixel to port B, and both leave on one strobe. The output strobe rate is therefore half the input pixel rate.

The depth and channel mode are sampled when a frame starts and are held for the rest of that frame, so a frame is never emitted in mixed formats. The output line-valid and frame-valid flags are delayed to match the data. When a line in dual mode ends on an unpaired even pixel, the flags are stretched by one cycle so that the padded final pair still falls inside the line.

Top module: `cam_pix_formatter`

## Requirements
- R1: After reset, every output is zero and the active format is 12-bit single-channel.
- R2: Depth code `00` places pixel bits 11:0 on port bits 11:0. Code `01` places pixel bits 11:2 on port bits 9:0. Code `10` places pixel bits 11:4 on port bits 7:0. Code `11` behaves as `00`. Unused upper port bits are zero.
- R3: In single-channel mode (`dual_i`=0), a pixel accepted in cycle n (`pix_vld_i` and `lval_i` high at the clock edge) appears on `port_a_o` with `strb_o` high in cycle n+1. `port_b_o` is zero in that cycle.
- R4: In dual mode (`dual_i`=1), pixels are counted from 0 at each line start. Pixel 2k is presented on `port_a_o` and pixel 2k+1 on `port_b_o` in the cycle after pixel 2k+1 is accepted, with exactly one strobe per pair.
- R5: In dual mode, a line with an odd pixel count ends with one extra strobe in the cycle after `lval_i` is first seen low. That strobe carries the last pixel on `port_a_o` and zero on `port_b_o`.
- R6: `lval_o` and `fval_o` follow `lval_i` and `fval_i` one cycle later. Each is held high for one extra cycle when the padded final pair of R5 is emitted. `strb_o` is high only while both are high.
- R7: The depth and mode inputs are sampled only in the cycle where `fval_i` rises, and that cycle already uses the new values. Changes at any other time have no effect until the next frame start.
- R8: In dual mode, `strb_o` is never high in two consecutive cycles within a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pix_i | input | 12 | Input pixel |
| pix_vld_i | input | 1 | Input pixel valid |
| lval_i | input | 1 | Input line valid |
| fval_i | input | 1 | Input frame valid |
| depth_sel_i | input | 2 | Depth code (see R2), sampled at frame start |
| dual_i | input | 1 | Dual-output mode select, sampled at frame start |
| port_a_o | output | 12 | Port A data (single pixel or even pixel) |
| port_b_o | output | 12 | Port B data (odd pixel in dual mode) |
| strb_o | output | 1 | Output data strobe |
| lval_o | output | 1 | Aligned line valid |
| fval_o | output | 1 | Aligned frame valid |

## Verification
The hardest situation to reach is a dual-mode line that ends on an unpaired pixel. In that case the final strobe is produced after `lval_i` has already dropped, and the valid flags must be stretched to cover it. The bench drives lines of odd length in dual mode at every depth. It checks the cycle of the padded strobe, the zero on port B, and the level of the flags at that moment. To show that a format change takes effect only at frame boundaries, the bench changes both mode inputs in the middle of a frame. It then checks that the rest of that frame keeps the old format and that the next frame adopts the new one.

// File: rtl/cam_fmt_pkg.sv
package cam_fmt_pkg;
  typedef enum logic [1:0] {
    DEPTH_12  = 2'b00,
    DEPTH_10  = 2'b01,
    DEPTH_8   = 2'b10,
    DEPTH_RSV = 2'b11
  } depth_e;

  typedef struct packed {
    logic   dual;
    depth_e depth;
  } fmt_cfg_t;

  localparam fmt_cfg_t CFG_RESET = '{dual: 1'b0, depth: DEPTH_12};
endpackage

// File: rtl/cam_fmt_cfg.sv
module cam_fmt_cfg
  import cam_fmt_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       fval_i,
  input  logic [1:0] depth_sel_i,
  input  logic       dual_i,
  output logic       fstart_o,
  output fmt_cfg_t   cfg_q_o,
  output fmt_cfg_t   cfg_eff_o
);
  logic     fval_q;
  fmt_cfg_t cfg_in;

  assign cfg_in    = '{dual: dual_i, depth: depth_e'(depth_sel_i)};
  assign fstart_o  = fval_i & ~fval_q;
  // new frame uses freshly sampled format from its first cycle
  assign cfg_eff_o = fstart_o ? cfg_in : cfg_q_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fval_q  <= 1'b0;
      cfg_q_o <= CFG_RESET;
    end else begin
      fval_q <= fval_i;
      if (fstart_o) cfg_q_o <= cfg_in;
    end
  end
endmodule

// File: rtl/cam_fmt_depth.sv
module cam_fmt_depth
  import cam_fmt_pkg::*;
#(
  parameter int PIX_W = 12
) (
  input  logic [PIX_W-1:0] pix_i,
  input  depth_e           depth_i,
  output logic [PIX_W-1:0] pix_o
);
  localparam int DROP_10 = PIX_W - 10;
  localparam int DROP_8  = PIX_W - 8;

  always_comb begin
    unique case (depth_i)
      DEPTH_10: pix_o = pix_i >> DROP_10;
      DEPTH_8:  pix_o = pix_i >> DROP_8;
      default:  pix_o = pix_i;
    endcase
  end
endmodule

// File: rtl/cam_fmt_pack.sv
module cam_fmt_pack #(
  parameter int PIX_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PIX_W-1:0] pix_i,
  input  logic             pix_vld_i,
  input  logic             lval_i,
  input  logic             fval_i,
  input  logic             dual_i,
  output logic [PIX_W-1:0] port_a_o,
  output logic [PIX_W-1:0] port_b_o,
  output logic             strb_o,
  output logic             lval_o,
  output logic             fval_o
);
  logic             lval_q;
  logic             have_even_q;
  logic [PIX_W-1:0] hold_q;
  logic             accept;
  logic             flush;

  assign accept = pix_vld_i & lval_i;
  // line ended on an unpaired even pixel
  assign flush  = lval_q & ~lval_i & have_even_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lval_q      <= 1'b0;
      have_even_q <= 1'b0;
      hold_q      <= '0;
      port_a_o    <= '0;
      port_b_o    <= '0;
      strb_o      <= 1'b0;
      lval_o      <= 1'b0;
      fval_o      <= 1'b0;
    end else begin
      lval_q <= lval_i;
      lval_o <= lval_i | flush;
      fval_o <= fval_i | flush;
      strb_o <= 1'b0;
      if (accept) begin
        if (!dual_i) begin
          port_a_o <= pix_i;
          port_b_o <= '0;
          strb_o   <= 1'b1;
        end else if (!have_even_q) begin
          hold_q      <= pix_i;
          have_even_q <= 1'b1;
        end else begin
          port_a_o    <= hold_q;
          port_b_o    <= pix_i;
          strb_o      <= 1'b1;
          have_even_q <= 1'b0;
        end
      end else if (flush) begin
        port_a_o    <= hold_q;
        port_b_o    <= '0;
        strb_o      <= 1'b1;
        have_even_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/cam_pix_formatter.sv
module cam_pix_formatter
  import cam_fmt_pkg::*;
#(
  parameter int PIX_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PIX_W-1:0] pix_i,
  input  logic             pix_vld_i,
  input  logic             lval_i,
  input  logic             fval_i,
  input  logic [1:0]       depth_sel_i,
  input  logic             dual_i,
  output logic [PIX_W-1:0] port_a_o,
  output logic [PIX_W-1:0] port_b_o,
  output logic             strb_o,
  output logic             lval_o,
  output logic             fval_o
);
  fmt_cfg_t         cfg_q;
  fmt_cfg_t         cfg_eff;
  logic             fstart;
  logic [PIX_W-1:0] pix_red;

  cam_fmt_cfg u_cfg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fval_i      (fval_i),
    .depth_sel_i (depth_sel_i),
    .dual_i      (dual_i),
    .fstart_o    (fstart),
    .cfg_q_o     (cfg_q),
    .cfg_eff_o   (cfg_eff)
  );

  cam_fmt_depth #(.PIX_W(PIX_W)) u_depth (
    .pix_i   (pix_i),
    .depth_i (cfg_eff.depth),
    .pix_o   (pix_red)
  );

  cam_fmt_pack #(.PIX_W(PIX_W)) u_pack (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pix_i     (pix_red),
    .pix_vld_i (pix_vld_i),
    .lval_i    (lval_i),
    .fval_i    (fval_i),
    .dual_i    (cfg_eff.dual),
    .port_a_o  (port_a_o),
    .port_b_o  (port_b_o),
    .strb_o    (strb_o),
    .lval_o    (lval_o),
    .fval_o    (fval_o)
  );
endmodule

// File: rtl/cam_fmt_chk.sv
module cam_fmt_chk #(
  parameter int PIX_W = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             pix_vld_i,
  input logic             lval_i,
  input logic [PIX_W-1:0] port_a_o,
  input logic [PIX_W-1:0] port_b_o,
  input logic             strb_o,
  input logic             lval_o,
  input logic             fval_o,
  input logic             fstart,
  input logic [2:0]       cfg_q,
  input logic [2:0]       cfg_eff
);
  assert_strb_framed_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strb_o |-> (lval_o && fval_o));

  assert_single_latency_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_vld_i && lval_i && !cfg_eff[2]) |=> (strb_o && port_b_o == '0));

  assert_dual_no_burst_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strb_o && cfg_q[2] && !fstart) |=> !strb_o);

  assert_depth8_upper_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strb_o && cfg_q[1:0] == 2'b10) |-> (port_a_o[PIX_W-1:8] == '0 && port_b_o[PIX_W-1:8] == '0));

  assert_depth10_upper_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strb_o && cfg_q[1:0] == 2'b01) |-> (port_a_o[PIX_W-1:10] == '0 && port_b_o[PIX_W-1:10] == '0));

  assert_cfg_frozen_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fstart |=> $stable(cfg_q));
endmodule

bind cam_pix_formatter cam_fmt_chk #(.PIX_W(PIX_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .pix_vld_i (pix_vld_i),
  .lval_i    (lval_i),
  .port_a_o  (port_a_o),
  .port_b_o  (port_b_o),
  .strb_o    (strb_o),
  .lval_o    (lval_o),
  .fval_o    (fval_o),
  .fstart    (fstart),
  .cfg_q     (cfg_q),
  .cfg_eff   (cfg_eff)
);

// File: tb/sim_cam_pix_formatter.sv
module sim_cam_pix_formatter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] pix = '0;
  logic        vld = 1'b0, lval = 1'b0, fval = 1'b0, dual = 1'b0;
  logic [1:0]  depth = 2'b00;
  logic [11:0] pa, pb;
  logic        strb, lv_o, fv_o;

  int total = 0, bad = 0, cyc = 0;
  int ncap = 0, unframed = 0;
  logic [11:0] cap_a [0:63];
  logic [11:0] cap_b [0:63];
  int          cap_c [0:63];

  cam_pix_formatter u0 (
    .clk_i(clk), .rst_ni(rst_n), .pix_i(pix), .pix_vld_i(vld), .lval_i(lval),
    .fval_i(fval), .depth_sel_i(depth), .dual_i(dual), .port_a_o(pa),
    .port_b_o(pb), .strb_o(strb), .lval_o(lv_o), .fval_o(fv_o));

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) if (strb) begin
    if (!(lv_o && fv_o)) unframed++;
    if (ncap < 64) begin
      cap_a[ncap] = pa; cap_b[ncap] = pb; cap_c[ncap] = cyc;
    end
    ncap++;
  end

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic logic [11:0] red(logic [11:0] p, logic [1:0] d);
    case (d)
      2'b01:   return {2'b00, p[11:2]};
      2'b10:   return {4'b0000, p[11:4]};
      default: return p;
    endcase
  endfunction

  function automatic logic [11:0] pval(int base, int i);
    return 12'(base + i * 37);
  endfunction

  task automatic frame_on(logic d, logic [1:0] dep);
    @(negedge clk); fval = 1'b1; dual = d; depth = dep;
    @(negedge clk);
  endtask

  task automatic frame_off();
    @(negedge clk); fval = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  // drive one line, check captured strobes against format md/dp
  task automatic line(string req, int n, int base, logic md, logic [1:0] dp);
    int c0, last_drv, end_drv, exp_n;
    c0 = ncap;
    last_drv = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); lval = 1'b1; vld = 1'b1; pix = pval(base, i); last_drv = cyc;
    end
    @(negedge clk); lval = 1'b0; vld = 1'b0; end_drv = cyc;
    repeat (3) @(negedge clk);
    exp_n = md ? (n + 1) / 2 : n;
    chk({req, " strobe count"}, ncap - c0, exp_n);
    for (int k = 0; k < exp_n && (c0 + k) < 64; k++) begin
      logic [11:0] ea, eb;
      if (!md) begin
        ea = red(pval(base, k), dp); eb = '0;
      end else begin
        ea = red(pval(base, 2 * k), dp);
        eb = (2 * k + 1 < n) ? red(pval(base, 2 * k + 1), dp) : 12'd0;
      end
      chk({req, " port A"}, int'(cap_a[c0 + k]), int'(ea));
      chk({req, " port B"}, int'(cap_b[c0 + k]), int'(eb));
    end
    if (md && (n % 2 == 1) && (c0 + exp_n - 1) < 64)
      chk("R5 padded strobe cycle", cap_c[c0 + exp_n - 1], end_drv + 1);
    else if ((c0 + exp_n - 1) < 64 && exp_n > 0)
      chk({req, " last strobe cycle"}, cap_c[c0 + exp_n - 1], last_drv + 1);
  endtask

  task automatic t_reset();
    chk("R1 port_a reset", int'(pa), 0);
    chk("R1 port_b reset", int'(pb), 0);
    chk("R1 strb/lval/fval reset", int'({strb, lv_o, fv_o}), 0);
  endtask

  task automatic t_single_depths();
    frame_on(1'b0, 2'b00); line("R3 R2 single 12b", 6, 100, 1'b0, 2'b00); frame_off();
    frame_on(1'b0, 2'b01); line("R2 single 10b", 5, 4000, 1'b0, 2'b01); frame_off();
    frame_on(1'b0, 2'b10); line("R2 single 8b", 4, 3000, 1'b0, 2'b10); frame_off();
    frame_on(1'b0, 2'b11); line("R2 code11 as 12b", 3, 2222, 1'b0, 2'b11); frame_off();
  endtask

  task automatic t_dual();
    frame_on(1'b1, 2'b00);
    line("R4 dual even line", 8, 500, 1'b1, 2'b00);
    line("R4 R5 dual odd line", 7, 900, 1'b1, 2'b00);
    frame_off();
    frame_on(1'b1, 2'b10); line("R5 dual odd 8b", 5, 1234, 1'b1, 2'b10); frame_off();
    frame_on(1'b1, 2'b01); line("R5 dual single-pixel 10b", 1, 3333, 1'b1, 2'b01); frame_off();
  endtask

  task automatic t_cfg_lock();
    frame_on(1'b0, 2'b00);
    @(negedge clk); dual = 1'b1; depth = 2'b10;  // mid-frame change, ignored (R7)
    line("R7 mid-frame change ignored", 4, 700, 1'b0, 2'b00);
    frame_off();
    frame_on(1'b1, 2'b10);
    line("R7 new format at next frame", 4, 700, 1'b1, 2'b10);
    frame_off();
  endtask

  // pixel presented in the very cycle fval rises uses the new format
  task automatic t_first_cycle();
    int c0;
    c0 = ncap;
    @(negedge clk); fval = 1'b1; dual = 1'b0; depth = 2'b10;
    lval = 1'b1; vld = 1'b1; pix = 12'hABC;
    @(negedge clk); vld = 1'b0; lval = 1'b0;
    repeat (2) @(negedge clk);
    chk("R7 frame-start cycle count", ncap - c0, 1);
    if (c0 < 64) chk("R7 frame-start cycle format", int'(cap_a[c0]), int'(12'h0AB));
    frame_off();
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_single_depths();
    t_dual();
    t_cfg_lock();
    t_first_cycle();
    chk("R6 R8 strobes outside valid", unframed, 0);
    @(negedge clk);
    chk("R6 flags low after frame", int'({lv_o, fv_o}), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule